// File: doc/BRIEF.md
# Printer Port Register Interface

This block is the byte-wide register file of a standard parallel printer port. A host bus sees it as eight consecutive byte addresses, decoded from the low three address bits. Behind those addresses sit five registers:

- a data latch that drives the port data lines;
- a status view that samples the port status lines;
- a control register that drives the port control lines;
- two pass-through registers for an enhanced-mode address byte and data byte.

The control register's direction bit picks where a data read comes from: the latched byte, or a fresh sample of the external data lines. The block watches a synchronized acknowledge input. When enabled, its falling edge raises a level interrupt, and a status read clears that interrupt.

The host bus is single-cycle. A cycle with `cs` high and `we` high is a write. A cycle with `cs` high and `we` low is a read, and its result appears on the registered `rdata` on the following cycle. Handshaking for the enhanced modes, DMA and cable timing are left to the logic around the block.

Top module: `printer_port_regs`

## Requirements
- R1: After reset the outputs are as follows: `rdata` = 0x00, `portDataOut` = 0x00, `portCtrlOut` = 0xC0, `ctrlPush` = 0 and `irq` = 0. The two enhanced-mode registers read back as 0x00.
- R2: A write at offset 0 latches `wdata`, and `portDataOut` shows that byte from the next cycle on.
- R3: A write at offset 2 stores `wdata` with bits 7 and 6 forced to 1. The stored value drives `portCtrlOut`, and a read at offset 2 returns it. Control bit 5 selects bidirectional mode and bit 4 enables the interrupt.
- R4: A control write changes `portCtrlOut` only when the forced value differs from the stored one. When it does, `ctrlPush` pulses high for exactly that one cycle, in which the new value first appears. `ctrlPush` is low in every other cycle.
- R5: A read at offset 0 returns the latched data byte when control bit 5 is 0. When control bit 5 is 1, it returns `portDataIn` as sampled in the read cycle.
- R6: A read at offset 1 returns `portStatusIn` as sampled in the read cycle. It also drives `irq` low from the next cycle on.
- R7: `ackIn` passes through a two-flop synchronizer. If control bit 4 is 1 when the synchronized acknowledge falls, `irq` goes high on the third rising clock edge after `ackIn` falls. If control bit 4 is 0, the edge leaves `irq` low.
- R8: Writes at offsets 3 and 4 store the enhanced-mode address and data bytes, and reads at offsets 3 and 4 return them.
- R9: Writes at offsets 1, 5, 6 and 7 change no register and no output.
- R10: Reads at offsets 5, 6 and 7 return 0xFF.
- R11: `rdata` changes only on the cycle after a read. It holds its value through idle cycles and through writes.
- R12: When an enabled acknowledge edge and a status read land in the same cycle, the interrupt is set: `irq` is 1 afterwards.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Bus cycle select |
| we | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| portDataOut | output | 8 | Data lines driven to the port |
| portCtrlOut | output | 8 | Control lines driven to the port |
| ctrlPush | output | 1 | One-cycle pulse when the control lines take a new value |
| portDataIn | input | 8 | Data lines sampled from the port |
| portStatusIn | input | 8 | Status lines sampled from the port |
| ackIn | input | 1 | Asynchronous acknowledge from the port, idle high |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check several properties on every cycle:
- the forced-high reserved control bits;
- the tie between `ctrlPush` and a change on the control lines;
- the data drive after a data write;
- the 0xFF returned by the unused offsets;
- `rdata` holding outside read cycles;
- the interrupt being cleared by a status read, being set only when enabled, and the set winning in a collision.

Some behaviours can only be shown by the bench's scenarios against its reference model. These are:
- the exact synchronizer latency from `ackIn` to `irq`;
- the data-read source switching with the direction bit;
- the suppression of a push when an equal control value is written;
- the ignored writes, observed through read-back.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int LPT_DW = 8;
  localparam int LPT_AW = 3;

  localparam logic [LPT_AW-1:0] OFF_DATA   = 3'd0;
  localparam logic [LPT_AW-1:0] OFF_STATUS = 3'd1;
  localparam logic [LPT_AW-1:0] OFF_CTRL   = 3'd2;
  localparam logic [LPT_AW-1:0] OFF_XADDR  = 3'd3;
  localparam logic [LPT_AW-1:0] OFF_XDATA  = 3'd4;

  localparam int BIT_BIDIR  = 5;
  localparam int BIT_ACKIRQ = 4;

  typedef struct packed {
    logic              wrData;
    logic              wrCtrl;
    logic              wrXAddr;
    logic              wrXData;
    logic              rdAny;
    logic              rdStatus;
    logic [LPT_AW-1:0] rdSel;
  } lptStrobes_t;
endpackage

// File: rtl/lptDecode.sv
module lptDecode
  import lpt_pkg::*;
(
  input  logic              cs,
  input  logic              we,
  input  logic [LPT_AW-1:0] addr,
  output lptStrobes_t       strobes
);
  logic wrCycle;
  logic rdCycle;

  assign wrCycle = cs && we;
  assign rdCycle = cs && !we;

  always_comb begin
    strobes          = '0;
    strobes.wrData   = wrCycle && (addr == OFF_DATA);
    strobes.wrCtrl   = wrCycle && (addr == OFF_CTRL);
    strobes.wrXAddr  = wrCycle && (addr == OFF_XADDR);
    strobes.wrXData  = wrCycle && (addr == OFF_XDATA);
    strobes.rdAny    = rdCycle;
    strobes.rdStatus = rdCycle && (addr == OFF_STATUS);
    strobes.rdSel    = addr;
  end
endmodule

// File: rtl/lptAckDetect.sv
module lptAckDetect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ackIn,
  output logic ackFall
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < CHAIN_W; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b1;
          else       chain[0] <= ackIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= 1'b1;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign ackFall = chain[CHAIN_W-1] && !chain[CHAIN_W-2];
endmodule

// File: rtl/lptDatapath.sv
module lptDatapath
  import lpt_pkg::*;
#(
  parameter logic [LPT_DW-1:0] CTRL_FORCE = 8'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  lptStrobes_t       strobes,
  input  logic [LPT_DW-1:0] wdata,
  input  logic [LPT_DW-1:0] portDataIn,
  input  logic [LPT_DW-1:0] portStatusIn,
  input  logic              ackFall,
  output logic [LPT_DW-1:0] rdata,
  output logic [LPT_DW-1:0] portDataOut,
  output logic [LPT_DW-1:0] portCtrlOut,
  output logic              ctrlPush,
  output logic              irq
);
  logic [LPT_DW-1:0] dataReg;
  logic [LPT_DW-1:0] ctrlReg;
  logic [LPT_DW-1:0] xAddrReg;
  logic [LPT_DW-1:0] xDataReg;
  logic [LPT_DW-1:0] rdataReg;
  logic [LPT_DW-1:0] ctrlNext;
  logic [LPT_DW-1:0] readMux;
  logic              ctrlDiffers;
  logic              pushReg;
  logic              irqReg;

  assign ctrlNext    = wdata | CTRL_FORCE;
  assign ctrlDiffers = ctrlNext != ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      xAddrReg <= '0;
      xDataReg <= '0;
    end else begin
      if (strobes.wrData)  dataReg  <= wdata;
      if (strobes.wrXAddr) xAddrReg <= wdata;
      if (strobes.wrXData) xDataReg <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_FORCE;
      pushReg <= 1'b0;
    end else begin
      pushReg <= strobes.wrCtrl && ctrlDiffers;
      if (strobes.wrCtrl && ctrlDiffers) ctrlReg <= ctrlNext;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      OFF_DATA:   readMux = ctrlReg[BIT_BIDIR] ? portDataIn : dataReg;
      OFF_STATUS: readMux = portStatusIn;
      OFF_CTRL:   readMux = ctrlReg;
      OFF_XADDR:  readMux = xAddrReg;
      OFF_XDATA:  readMux = xDataReg;
      default:    readMux = {LPT_DW{1'b1}};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdataReg <= '0;
    else if (strobes.rdAny) rdataReg <= readMux;
  end

  // A new acknowledge edge takes priority over the clear from a status read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                irqReg <= 1'b0;
    else if (ackFall && ctrlReg[BIT_ACKIRQ])  irqReg <= 1'b1;
    else if (strobes.rdStatus)                irqReg <= 1'b0;
  end

  assign rdata       = rdataReg;
  assign portDataOut = dataReg;
  assign portCtrlOut = ctrlReg;
  assign ctrlPush    = pushReg;
  assign irq         = irqReg;
endmodule

// File: rtl/printer_port_regs.sv
module printer_port_regs
  import lpt_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [LPT_DW-1:0] CTRL_FORCE  = 8'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              we,
  input  logic [LPT_AW-1:0] addr,
  input  logic [LPT_DW-1:0] wdata,
  output logic [LPT_DW-1:0] rdata,
  output logic [LPT_DW-1:0] portDataOut,
  output logic [LPT_DW-1:0] portCtrlOut,
  output logic              ctrlPush,
  input  logic [LPT_DW-1:0] portDataIn,
  input  logic [LPT_DW-1:0] portStatusIn,
  input  logic              ackIn,
  output logic              irq
);
  lptStrobes_t strobes;
  logic        ackFall;

  lptDecode u_decode (
    .cs      (cs),
    .we      (we),
    .addr    (addr),
    .strobes (strobes)
  );

  lptAckDetect #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
    .clk     (clk),
    .rstN    (rstN),
    .ackIn   (ackIn),
    .ackFall (ackFall)
  );

  lptDatapath #(.CTRL_FORCE(CTRL_FORCE)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .wdata        (wdata),
    .portDataIn   (portDataIn),
    .portStatusIn (portStatusIn),
    .ackFall      (ackFall),
    .rdata        (rdata),
    .portDataOut  (portDataOut),
    .portCtrlOut  (portCtrlOut),
    .ctrlPush     (ctrlPush),
    .irq          (irq)
  );
endmodule

// File: rtl/lptRegsChecker.sv
module lptRegsChecker
  import lpt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cs,
  input logic              we,
  input logic [LPT_AW-1:0] addr,
  input logic [LPT_DW-1:0] wdata,
  input logic [LPT_DW-1:0] rdata,
  input logic [LPT_DW-1:0] portDataOut,
  input logic [LPT_DW-1:0] portCtrlOut,
  input logic              ctrlPush,
  input logic              ackFall,
  input logic              irq
);
  logic statusRead;
  logic unusedRead;
  assign statusRead = cs && !we && (addr == OFF_STATUS);
  assign unusedRead = cs && !we && (addr >= 3'd5);

  a_r3_reserved_high: assert property (@(posedge clk) disable iff (!rstN)
    portCtrlOut[7:6] == 2'b11);

  a_r4_push_means_change: assert property (@(posedge clk) disable iff (!rstN)
    ctrlPush |-> (portCtrlOut != $past(portCtrlOut)));

  a_r4_no_push_stable: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlPush |-> $stable(portCtrlOut));

  a_r2_data_drive: assert property (@(posedge clk) disable iff (!rstN)
    (cs && we && addr == OFF_DATA) |=> (portDataOut == $past(wdata)));

  a_r10_unused_reads_ff: assert property (@(posedge clk) disable iff (!rstN)
    unusedRead |=> (rdata == 8'hFF));

  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(cs && !we) |=> $stable(rdata));

  a_r6_status_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !ackFall) |=> !irq);

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && ackFall && portCtrlOut[BIT_ACKIRQ]) |=> irq);

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(ackFall) && $past(portCtrlOut[BIT_ACKIRQ])));
endmodule

bind printer_port_regs lptRegsChecker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cs          (cs),
  .we          (we),
  .addr        (addr),
  .wdata       (wdata),
  .rdata       (rdata),
  .portDataOut (portDataOut),
  .portCtrlOut (portCtrlOut),
  .ctrlPush    (ctrlPush),
  .ackFall     (ackFall),
  .irq         (irq)
);

// File: tb/printer_port_regs_bench.sv
`timescale 1ns/1ps
module printer_port_regs_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] portDataIn = '0;
  logic [7:0] portStatusIn = '0;
  logic       ackIn = 1'b1;
  logic [7:0] rdata;
  logic [7:0] portDataOut;
  logic [7:0] portCtrlOut;
  logic       ctrlPush;
  logic       irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int pushCount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  printer_port_regs u_printer_port_regs (
    .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .portDataOut(portDataOut), .portCtrlOut(portCtrlOut),
    .ctrlPush(ctrlPush), .portDataIn(portDataIn), .portStatusIn(portStatusIn),
    .ackIn(ackIn), .irq(irq)
  );

  // Behavioural reference model, advanced on each rising edge.
  int  mData, mCtrl, mXA, mXD, mRd;
  bit  mIrq, mPush;
  bit  ackHist[$];

  initial begin
    mData = 0; mCtrl = 'hC0; mXA = 0; mXD = 0; mRd = 0; mIrq = 0; mPush = 0;
    ackHist = '{1, 1, 1};
  end

  always @(posedge clk) begin
    int  oldCtrl;
    int  nv;
    bit  fall;
    if (!rstN) begin
      mData = 0; mCtrl = 'hC0; mXA = 0; mXD = 0; mRd = 0; mIrq = 0; mPush = 0;
      ackHist = '{1, 1, 1};
    end else begin
      // ackHist[0] is the oldest synchronized sample.
      fall = ackHist[0] && !ackHist[1];
      void'(ackHist.pop_front());
      ackHist.push_back(ackIn);
      oldCtrl = mCtrl;
      mPush = 0;
      if (cs && we) begin
        case (addr)
          3'd0: mData = wdata;
          3'd2: begin
            nv = wdata | 'hC0;
            if (nv != mCtrl) begin mCtrl = nv; mPush = 1; end
          end
          3'd3: mXA = wdata;
          3'd4: mXD = wdata;
          default: ;
        endcase
      end
      if (cs && !we) begin
        case (addr)
          3'd0: mRd = oldCtrl[5] ? portDataIn : mData;
          3'd1: begin mRd = portStatusIn; mIrq = 0; end
          3'd2: mRd = oldCtrl;
          3'd3: mRd = mXA;
          3'd4: mRd = mXD;
          default: mRd = 'hFF;
        endcase
      end
      if (fall && oldCtrl[4]) mIrq = 1;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison with the model, away from the active edge.
  always @(negedge clk) begin
    if (ctrlPush) pushCount++;
    check("R11 rdata vs model", rdata, mRd);
    check("R2 portDataOut vs model", portDataOut, mData);
    check("R3 portCtrlOut vs model", portCtrlOut, mCtrl);
    check("R4 ctrlPush vs model", ctrlPush, mPush);
    check("R7 irq vs model", irq, mIrq);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    cs = 1; we = 0; addr = a;
    @(negedge clk);
    cs = 0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    logic [7:0] hold;
    int pc0;
    idle(3);
    // R1 reset state
    check("R1 rdata", rdata, 'h00);
    check("R1 portDataOut", portDataOut, 'h00);
    check("R1 portCtrlOut", portCtrlOut, 'hC0);
    check("R1 irq", irq, 0);
    rstN = 1;
    idle(2);
    busRead(3'd3, r); check("R1 xaddr reset", r, 'h00);
    busRead(3'd4, r); check("R1 xdata reset", r, 'h00);

    // R2 data write and drive
    busWrite(3'd0, 8'hA5);
    check("R2 data drive", portDataOut, 'hA5);
    busRead(3'd0, r); check("R5 latched read", r, 'hA5);

    // R4 equal value: no push
    pc0 = pushCount;
    busWrite(3'd2, 8'h00);
    idle(1);
    check("R4 no push on equal", pushCount - pc0, 0);
    check("R4 ctrl unchanged", portCtrlOut, 'hC0);
    // R3 forced bits, R4 push on change
    busWrite(3'd2, 8'h15);
    idle(1);
    check("R3 forced ctrl", portCtrlOut, 'hD5);
    check("R4 one push", pushCount - pc0, 1);
    busRead(3'd2, r); check("R3 ctrl readback", r, 'hD5);

    // R5 bidirectional read
    busWrite(3'd2, 8'h20);
    portDataIn = 8'h3C;
    busRead(3'd0, r); check("R5 bidir read", r, 'h3C);
    portDataIn = 8'h77;
    busRead(3'd0, r); check("R5 bidir fresh", r, 'h77);
    busWrite(3'd2, 8'h10);
    busRead(3'd0, r); check("R5 back to latch", r, 'hA5);

    // R8 enhanced-mode registers
    busWrite(3'd3, 8'h12);
    busWrite(3'd4, 8'h34);
    busRead(3'd3, r); check("R8 xaddr", r, 'h12);
    busRead(3'd4, r); check("R8 xdata", r, 'h34);

    // R11 rdata holds through writes and idle
    hold = rdata;
    busWrite(3'd0, 8'hA5);
    idle(2);
    check("R11 rdata hold", rdata, hold);

    // R9 ignored writes
    pc0 = pushCount;
    for (int a = 5; a < 8; a++) busWrite(a[2:0], 8'h55);
    busWrite(3'd1, 8'h55);
    check("R9 data out", portDataOut, 'hA5);
    check("R9 ctrl out", portCtrlOut, 'hD0);
    check("R9 no push", pushCount - pc0, 0);
    busRead(3'd0, r); check("R9 data reg", r, 'hA5);
    busRead(3'd3, r); check("R9 xaddr", r, 'h12);
    busRead(3'd4, r); check("R9 xdata", r, 'h34);

    // R10 unused reads
    for (int a = 5; a < 8; a++) begin
      busRead(a[2:0], r); check("R10 unused read", r, 'hFF);
    end

    // R7 enabled acknowledge raises irq on the third edge
    ackIn = 0;
    idle(2);
    check("R7 irq not yet", irq, 0);
    idle(1);
    check("R7 irq set", irq, 1);
    ackIn = 1;
    idle(3);
    check("R7 irq level held", irq, 1);
    // R6 status read
    portStatusIn = 8'h9B;
    busRead(3'd1, r);
    check("R6 status value", r, 'h9B);
    check("R6 irq cleared", irq, 0);

    // R7 disabled: no interrupt
    busWrite(3'd2, 8'h00);
    ackIn = 0; idle(5); ackIn = 1; idle(3);
    check("R7 disabled no irq", irq, 0);

    // R12 collision of set and clear
    busWrite(3'd2, 8'h10);
    idle(3);
    ackIn = 0;
    idle(2);
    busRead(3'd1, r);
    check("R12 set wins", irq, 1);
    ackIn = 1;
    idle(3);
    busRead(3'd1, r);
    check("R6 later clear", irq, 0);

    idle(2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule